// File: doc/BRIEF.md
# Dual Full-Match Alarm Unit

This block watches a running calendar time, held as six BCD bytes (second, minute, hour, day, month, year), and compares it against two independently programmed alarm sets. A comparison is made only on the cycle that carries the once-per-second update strobe. An alarm fires only when every one of the six fields equals its stored value; no field can be marked as "any". Each alarm, and the second strobe itself, sets a sticky event flag that software clears by writing a one to it.

The flags drive three outputs. The interrupt line is the OR of each pending event whose enable bit is set. The wake request follows the first alarm's flag when its wake enable is set. The power-enable pin comes out of reset high. If power-control mode is armed, a match on the second alarm drives it low, and it stays low until the next reset. The alarm storage, enables and power-control word sit on a simple write port with a combinational read port.

Top module: `alrm_unit`

## Requirements
- R1: Alarm set A (byte registers at 0x20, 0x24, 0x28, 0x2C, 0x30, 0x34 holding second, minute, hour, day, month, year) sets status bit 6 only when the strobe is high and all six fields of `now_time` equal it. A difference in any single field sets nothing.
- R2: Alarm set B (0x80 through 0x94, same field order and 4-byte step) sets status bit 7 under the same full-match rule.
- R3: Status bits (0x44) are sticky. Writing 1 to bit 7, 6 or 2 clears that bit, and writing 0 leaves it unchanged.
- R4: When an event and a clear of the same bit occur in the same cycle, the bit ends set.
- R5: `irq` is high exactly when a pending status bit has its enable set in register 0x48: bit 2 for the second event, bit 3 for alarm A, bit 4 for alarm B.
- R6: `wake_req` is high exactly when status bit 6 is set and bit 1 of register 0x7C is set.
- R7: With bit 16 of register 0x98 set, an alarm B match drives `pwr_en` low one cycle later, and it stays low until reset, even after the status is cleared. With bit 16 clear, an alarm B match leaves `pwr_en` high.
- R8: Readback returns each alarm byte in bits 7:0. Register 0x48 returns only bits 4:2, register 0x7C only bit 1, and register 0x98 only bit 16 and bits 7:0. Bits 7:0 of 0x98 hold the external wake input enables (bits 3:0) and the polarity bits (7:4, 1 = active low). Unmapped addresses read as 0.
- R9: After reset, all registers and status bits are 0, `irq` and `wake_req` are low and `pwr_en` is high.
- R10: With the strobe low, a time equal to an alarm sets no status bit.
- R11: Every strobe sets status bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle strobe that marks a new second |
| now_time | input | 48 | Current time, BCD, second in 7:0 up to year in 47:40 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 32 | Combinational read data |
| irq | output | 1 | Interrupt request |
| wake_req | output | 1 | Wake request from alarm A |
| pwr_en | output | 1 | External power enable, low means off |

## Verification
The hardest case to reach from the ports is a near miss: a time that differs from a stored alarm in exactly one field while the strobe is high. Random times almost never come that close. The stimulus therefore builds times by flipping one field of a programmed alarm, mixes them with exact hits and unrelated random times, and walks every field position in a directed pass. A second hard case is a status clear that lands in the same cycle as the event it clears. The bench reaches it by issuing a write to the status register together with a matching strobe. The one-way power latch is covered by arming power control and then clearing status and rewriting the control word after the drop.

// File: rtl/alrm_pkg.sv
`timescale 1ns/1ps
package alrm_pkg;
  localparam int unsigned FLD_W      = 8;
  localparam int unsigned FLD_N      = 6;
  localparam int unsigned REG_STRIDE = 4;

  localparam logic [7:0] A1_BASE  = 8'h20;
  localparam logic [7:0] A2_BASE  = 8'h80;
  localparam logic [7:0] STAT_ADR = 8'h44;
  localparam logic [7:0] IEN_ADR  = 8'h48;
  localparam logic [7:0] WAKE_ADR = 8'h7C;
  localparam logic [7:0] PWR_ADR  = 8'h98;

  localparam int unsigned ST_SEC_B  = 2;
  localparam int unsigned ST_A1_B   = 6;
  localparam int unsigned ST_A2_B   = 7;
  localparam int unsigned IE_SEC_B  = 2;
  localparam int unsigned IE_A1_B   = 3;
  localparam int unsigned IE_A2_B   = 4;
  localparam int unsigned WK_A1_B   = 1;
  localparam int unsigned PW_CTL_B  = 16;
  localparam int unsigned PIN_CFG_W = 8;

  typedef struct packed {
    logic a2;
    logic a1;
    logic sec;
  } evt_t;
endpackage

// File: rtl/alrm_cmp.sv
`timescale 1ns/1ps
module alrm_cmp #(
  parameter int NFLD = 6,
  parameter int FW   = 8
) (
  input  logic               tick,
  input  logic [NFLD*FW-1:0] now_v,
  input  logic [NFLD*FW-1:0] set_v,
  output logic               hit
);
  logic [NFLD-1:0] fld_eq;

  for (genvar g = 0; g < NFLD; g++) begin : g_fld
    assign fld_eq[g] = (now_v[g*FW +: FW] == set_v[g*FW +: FW]);
  end

  assign hit = tick & (&fld_eq);
endmodule

// File: rtl/alrm_regs.sv
`timescale 1ns/1ps
module alrm_regs
  import alrm_pkg::*;
#(
  parameter int AW   = 8,
  parameter int DW   = 32,
  parameter int NFLD = 6,
  parameter int FW   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic [AW-1:0]      rd_addr,
  input  evt_t               stat,
  output logic [NFLD*FW-1:0] a1_v,
  output logic [NFLD*FW-1:0] a2_v,
  output evt_t               ien,
  output logic               wake_a1_en,
  output logic               pwr_ctl_en,
  output logic [DW-1:0]      rd_data
);
  localparam int NSET   = 2;
  localparam int VEC_W  = NFLD * FW;
  localparam int ALL_W  = NSET * VEC_W;

  function automatic logic [AW-1:0] fld_adr(input int k, input int g);
    int base;
    base = (k == 0) ? int'(A1_BASE) : int'(A2_BASE);
    return AW'(base + g * int'(REG_STRIDE));
  endfunction

  logic [ALL_W-1:0] all_v;
  logic             unused_wd;

  assign unused_wd = ^wr_data;

  for (genvar k = 0; k < NSET; k++) begin : g_set
    for (genvar g = 0; g < NFLD; g++) begin : g_fld
      logic          sel;
      logic [FW-1:0] fld_d;
      logic [FW-1:0] fld_q;

      assign sel = wr_en && (wr_addr == fld_adr(k, g));

      always_comb begin
        fld_d = fld_q;
        if (sel) fld_d = wr_data[FW-1:0];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fld_q <= '0;
        else        fld_q <= fld_d;
      end

      assign all_v[(k*NFLD+g)*FW +: FW] = fld_q;
    end
  end

  assign a1_v = all_v[VEC_W-1:0];
  assign a2_v = all_v[ALL_W-1:VEC_W];

  evt_t                 ien_q, ien_d;
  logic                 wake_q, wake_d;
  logic                 pctl_q, pctl_d;
  logic [PIN_CFG_W-1:0] pin_q, pin_d;

  always_comb begin
    ien_d  = ien_q;
    wake_d = wake_q;
    pctl_d = pctl_q;
    pin_d  = pin_q;
    if (wr_en) begin
      if (wr_addr == AW'(IEN_ADR)) begin
        ien_d.a2  = wr_data[IE_A2_B];
        ien_d.a1  = wr_data[IE_A1_B];
        ien_d.sec = wr_data[IE_SEC_B];
      end
      if (wr_addr == AW'(WAKE_ADR)) wake_d = wr_data[WK_A1_B];
      if (wr_addr == AW'(PWR_ADR)) begin
        pctl_d = wr_data[PW_CTL_B];
        pin_d  = wr_data[PIN_CFG_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= '0;
      wake_q <= 1'b0;
      pctl_q <= 1'b0;
      pin_q  <= '0;
    end else begin
      ien_q  <= ien_d;
      wake_q <= wake_d;
      pctl_q <= pctl_d;
      pin_q  <= pin_d;
    end
  end

  assign ien        = ien_q;
  assign wake_a1_en = wake_q;
  assign pwr_ctl_en = pctl_q;

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NSET; k++) begin
      for (int g = 0; g < NFLD; g++) begin
        if (rd_addr == fld_adr(k, g)) rd_data[FW-1:0] = all_v[(k*NFLD+g)*FW +: FW];
      end
    end
    if (rd_addr == AW'(STAT_ADR)) begin
      rd_data[ST_A2_B]  = stat.a2;
      rd_data[ST_A1_B]  = stat.a1;
      rd_data[ST_SEC_B] = stat.sec;
    end
    if (rd_addr == AW'(IEN_ADR)) begin
      rd_data[IE_A2_B]  = ien_q.a2;
      rd_data[IE_A1_B]  = ien_q.a1;
      rd_data[IE_SEC_B] = ien_q.sec;
    end
    if (rd_addr == AW'(WAKE_ADR)) rd_data[WK_A1_B] = wake_q;
    if (rd_addr == AW'(PWR_ADR)) begin
      rd_data[PW_CTL_B]        = pctl_q;
      rd_data[PIN_CFG_W-1:0]   = pin_q;
    end
  end
endmodule

// File: rtl/alrm_evt.sv
`timescale 1ns/1ps
module alrm_evt
  import alrm_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit1,
  input  logic          hit2,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  evt_t          ien,
  input  logic          wake_a1_en,
  input  logic          pwr_ctl_en,
  output evt_t          stat,
  output logic          irq,
  output logic          wake_req,
  output logic          pwr_en
);
  evt_t st_q, st_d, set_v, clr_v;
  logic pw_q, pw_d;
  logic unused_wd;

  assign unused_wd = ^wr_data;

  always_comb begin
    clr_v = '0;
    if (wr_en && (wr_addr == AW'(STAT_ADR))) begin
      clr_v.a2  = wr_data[ST_A2_B];
      clr_v.a1  = wr_data[ST_A1_B];
      clr_v.sec = wr_data[ST_SEC_B];
    end
    set_v.a2  = hit2;
    set_v.a1  = hit1;
    set_v.sec = tick;
    st_d      = (st_q & ~clr_v) | set_v;
    pw_d      = pw_q & ~(hit2 & pwr_ctl_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
      pw_q <= 1'b1;
    end else begin
      st_q <= st_d;
      pw_q <= pw_d;
    end
  end

  assign stat     = st_q;
  assign irq      = |(st_q & ien);
  assign wake_req = st_q.a1 & wake_a1_en;
  assign pwr_en   = pw_q;
endmodule

// File: rtl/alrm_unit.sv
`timescale 1ns/1ps
module alrm_unit
  import alrm_pkg::*;
#(
  parameter int AW   = 8,
  parameter int DW   = 32,
  parameter int NFLD = FLD_N,
  parameter int FW   = FLD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sec_tick,
  input  logic [NFLD*FW-1:0] now_time,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic [AW-1:0]      rd_addr,
  output logic [DW-1:0]      rd_data,
  output logic               irq,
  output logic               wake_req,
  output logic               pwr_en
);
  logic [NFLD*FW-1:0] a1_v, a2_v;
  evt_t               ien_w, stat_w;
  logic               wake_en_w, pctl_w, hit1_w, hit2_w;

  alrm_regs #(.AW(AW), .DW(DW), .NFLD(NFLD), .FW(FW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .stat(stat_w), .a1_v(a1_v), .a2_v(a2_v), .ien(ien_w),
    .wake_a1_en(wake_en_w), .pwr_ctl_en(pctl_w), .rd_data(rd_data)
  );

  alrm_cmp #(.NFLD(NFLD), .FW(FW)) u_cmp_a (
    .tick(sec_tick), .now_v(now_time), .set_v(a1_v), .hit(hit1_w)
  );

  alrm_cmp #(.NFLD(NFLD), .FW(FW)) u_cmp_b (
    .tick(sec_tick), .now_v(now_time), .set_v(a2_v), .hit(hit2_w)
  );

  alrm_evt #(.AW(AW), .DW(DW)) u_evt (
    .clk(clk), .rst_n(rst_n), .hit1(hit1_w), .hit2(hit2_w), .tick(sec_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .ien(ien_w),
    .wake_a1_en(wake_en_w), .pwr_ctl_en(pctl_w), .stat(stat_w),
    .irq(irq), .wake_req(wake_req), .pwr_en(pwr_en)
  );
endmodule

// File: rtl/alrm_unit_chk.sv
`timescale 1ns/1ps
module alrm_unit_chk
  import alrm_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sec_tick,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          irq,
  input logic          wake_req,
  input logic          pwr_en,
  input evt_t          stat
);
  logic clr_a1;
  assign clr_a1 = wr_en && (wr_addr == AW'(STAT_ADR)) && wr_data[ST_A1_B];

  AST_A1_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat.a1) |-> $past(sec_tick)); // R1
  AST_A2_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat.a2) |-> $past(sec_tick)); // R2
  AST_A1_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat.a1 && !clr_a1) |=> stat.a1); // R3
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat != '0)); // R5
  AST_WAKE_HAS_A1: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> stat.a1); // R6
  AST_PWR_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |=> !pwr_en); // R7
  AST_PWR_FALL_BY_A2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_en) |-> stat.a2); // R7
  AST_SEC_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat.sec) |-> $past(sec_tick)); // R11
endmodule

bind alrm_unit alrm_unit_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .irq(irq), .wake_req(wake_req), .pwr_en(pwr_en), .stat(stat_w)
);

// File: tb/alrm_unit_test.sv
`timescale 1ns/1ps
module alrm_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sec_tick;
  logic [47:0] now_time;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [31:0] wr_data;
  logic [7:0]  rd_addr;
  logic [31:0] rd_data;
  logic        irq, wake_req, pwr_en;

  always #2.5 clk = ~clk;

  alrm_unit uut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .now_time(now_time),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq), .wake_req(wake_req), .pwr_en(pwr_en)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference state
  logic [47:0] m_al [2];
  logic [2:0]  m_ien;   // [0]=second, [1]=alarm A, [2]=alarm B
  logic        m_wake;
  logic        m_pctl;
  logic [7:0]  m_pin;
  logic [2:0]  m_st;    // [0]=second, [1]=alarm A, [2]=alarm B
  logic        m_pwr;

  localparam logic [47:0] TA = 48'h25_06_15_13_45_30;
  localparam logic [47:0] TB = 48'h25_06_15_13_45_32;

  function automatic logic [7:0] fadr(input int k, input int g);
    return (k == 0 ? 8'h20 : 8'h80) + 8'(g * 4);
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    logic [31:0] r = '0;
    for (int k = 0; k < 2; k++)
      for (int g = 0; g < 6; g++)
        if (a == fadr(k, g)) r[7:0] = m_al[k][g*8 +: 8];
    if (a == 8'h44) begin r[7] = m_st[2]; r[6] = m_st[1]; r[2] = m_st[0]; end
    if (a == 8'h48) r[4:2] = m_ien;
    if (a == 8'h7C) r[1] = m_wake;
    if (a == 8'h98) begin r[16] = m_pctl; r[7:0] = m_pin; end
    return r;
  endfunction

  function automatic logic exp_irq();
    return |(m_st & m_ien);
  endfunction

  function automatic logic [7:0] rbcd(input int lim, input int off);
    int v = int'($urandom % lim) + off;
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic logic [47:0] rtime();
    return {rbcd(100, 0), rbcd(12, 1), rbcd(28, 1), rbcd(24, 0), rbcd(60, 0), rbcd(60, 0)};
  endfunction

  task automatic model_reset();
    m_al[0] = '0; m_al[1] = '0; m_ien = '0; m_wake = 0; m_pctl = 0;
    m_pin = '0; m_st = '0; m_pwr = 1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a);
    rd_addr = a;
    #0.5;
    chk(req, rd_data, exp_read(a));
    rd_addr = 8'h44;
  endtask

  task automatic chk_all(input string req);
    chk({req, " irq"}, 32'(irq), 32'(exp_irq()));
    chk({req, " wake"}, 32'(wake_req), 32'(m_st[1] & m_wake));
    chk({req, " pwr"}, 32'(pwr_en), 32'(m_pwr));
    rd_chk({req, " status"}, 8'h44);
  endtask

  task automatic step(input bit we, input logic [7:0] a, input logic [31:0] d,
                      input bit tk, input logic [47:0] t);
    logic h1, h2, oldc;
    logic [2:0] clr, setv;
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; sec_tick = tk; now_time = t;
    @(posedge clk);
    h1 = tk && (t == m_al[0]);
    h2 = tk && (t == m_al[1]);
    oldc = m_pctl;
    clr = '0;
    if (we) begin
      for (int k = 0; k < 2; k++)
        for (int g = 0; g < 6; g++)
          if (a == fadr(k, g)) m_al[k][g*8 +: 8] = d[7:0];
      if (a == 8'h44) clr = {d[7], d[6], d[2]};
      if (a == 8'h48) m_ien = d[4:2];
      if (a == 8'h7C) m_wake = d[1];
      if (a == 8'h98) begin m_pctl = d[16]; m_pin = d[7:0]; end
    end
    setv = {h2, h1, tk};
    m_st = (m_st & ~clr) | setv;
    if (h2 && oldc) m_pwr = 0;
    #1;
    wr_en = 0; sec_tick = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_A1A2));
    rst_n = 1; sec_tick = 0; now_time = '0; wr_en = 0; wr_addr = '0; wr_data = '0;
    rd_addr = 8'h44;
    #1 rst_n = 0;
    do_reset();

    // R9 reset state
    chk_all("R9 reset");
    rd_chk("R9 reset ien", 8'h48);
    rd_chk("R9 reset pwrctl", 8'h98);

    // R8 program both alarm sets and read back
    for (int g = 0; g < 6; g++) step(1, fadr(0, g), 32'(TA[g*8 +: 8]), 0, '0);
    for (int g = 0; g < 6; g++) step(1, fadr(1, g), 32'hFFFF_FF00 | 32'(TB[g*8 +: 8]), 0, '0);
    for (int k = 0; k < 2; k++)
      for (int g = 0; g < 6; g++) rd_chk("R8 alarm field", fadr(k, g));
    step(1, 8'h48, 32'hFFFF_FFFF, 0, '0);
    rd_chk("R8 ien bits", 8'h48);
    step(1, 8'h7C, 32'hFFFF_FFFF, 0, '0);
    rd_chk("R8 wake bit", 8'h7C);
    step(1, 8'h98, 32'h0000_00A5, 0, '0);
    rd_chk("R8 pin cfg", 8'h98);
    rd_chk("R8 unmapped", 8'h3C);
    step(1, 8'h48, 0, 0, '0);
    step(1, 8'h7C, 0, 0, '0);
    step(1, 8'h98, 0, 0, '0);

    // R10 matching time without strobe
    step(0, 0, 0, 0, TA);
    chk_all("R10 no strobe");

    // R1 near misses in each field; R11 second event still set
    for (int g = 0; g < 6; g++) begin
      step(0, 0, 0, 1, TA ^ (48'h01 << (g * 8)));
      chk_all("R1 near miss");
      chk("R11 sec event", 32'(m_st[0]), 32'd1);
    end
    step(1, 8'h44, 32'h04, 0, '0);

    // R1 full match, R5 masked then enabled
    step(0, 0, 0, 1, TA);
    chk_all("R1 full match");
    step(1, 8'h48, 32'h08, 0, '0);
    chk_all("R5 alarm A enable");
    step(1, 8'h7C, 32'h02, 0, '0);
    chk_all("R6 wake");

    // R3 W1C semantics
    step(1, 8'h44, 32'h00, 0, '0);
    chk_all("R3 write zero");
    step(1, 8'h44, 32'h40, 0, '0);
    chk_all("R3 clear A");

    // R4 set wins over clear
    step(1, 8'h44, 32'hC4, 1, TA);
    chk_all("R4 set vs clear");
    step(1, 8'h44, 32'hC4, 0, '0);

    // R2 / R7 power control off then on
    step(1, 8'h48, 32'h10, 0, '0);
    step(0, 0, 0, 1, TB);
    chk_all("R7 ctl off");
    chk("R2 alarm B", 32'(m_st[2]), 32'd1);
    step(1, 8'h98, 32'h0001_0000, 0, '0);
    step(0, 0, 0, 1, TB);
    chk_all("R7 power drop");
    step(1, 8'h44, 32'hFF, 0, '0);
    step(1, 8'h98, 32'h0, 0, '0);
    chk_all("R7 stays off");

    do_reset();
    chk_all("R9 second reset");

    // random mix
    for (int g = 0; g < 6; g++) step(1, fadr(0, g), 32'(TA[g*8 +: 8]), 0, '0);
    for (int g = 0; g < 6; g++) step(1, fadr(1, g), 32'(TB[g*8 +: 8]), 0, '0);
    for (int i = 0; i < 600; i++) begin
      logic [47:0] t;
      logic [7:0]  a;
      logic [31:0] d;
      int sel = int'($urandom % 8);
      case (sel)
        0, 1: t = m_al[0];
        2:    t = m_al[1];
        3, 4: t = m_al[$urandom % 2] ^ (48'h01 << (8 * ($urandom % 6)));
        default: t = rtime();
      endcase
      case ($urandom % 6)
        0: a = 8'h44;
        1: a = 8'h48;
        2: a = 8'h7C;
        3: a = (($urandom % 16) == 0) ? 8'h98 : 8'h48;
        default: a = fadr($urandom % 2, $urandom % 6);
      endcase
      d = $urandom;
      if (a != 8'h44 && a != 8'h48 && a != 8'h7C && a != 8'h98) d[7:0] = t[8*($urandom % 6) +: 8];
      step(($urandom % 3) == 0, a, d, ($urandom % 2) == 1, t);
      chk_all("R1 R2 R5 R6 R7 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule